// File: doc/BRIEF.md
# SD SPI Block Read Receiver

This block sits between a byte-wide SPI transfer engine and a downstream byte consumer. Once a read command has been issued to an SD or MMC card, the block takes over the data phase. It fetches one byte at a time from the card and discards the idle bytes that come before the data start marker. It then passes the payload bytes to the consumer through a valid/ready interface. After the payload it takes in the two trailing check bytes and, if checking is enabled, compares them with a CRC it computes locally.

A single start pulse carries the number of blocks, the block length and the token search budget. All blocks are received back to back without another command; the 16-byte card identification and card-specific data registers are read as one 16-byte block. At the end the block pulses a completion flag. A result code goes with it and stays valid until the next start.

Top module: `sdrd_block_rx`

## Requirements
- R1: While reset is held and just after it, no byte request is made, out_valid, done and busy are low, and result is 0.
- R2: Bytes received before the start marker 0xFE are consumed and never appear on out_data, and neither does the marker.
- R3: If 0xFE is not among the first tok_limit bytes fetched for a block (a limit of 0 counts as 1), exactly tok_limit bytes are fetched for that block. Completion then carries result 2 (timeout), and no later byte is fetched.
- R4: After the marker, exactly blk_size payload bytes are delivered on out_data in arrival order, followed by two check bytes that are fetched but not delivered.
- R5: A new byte request is never raised while out_valid is high, and out_data stays unchanged while out_valid is high and out_ready is low.
- R6: With crc_check high, the two check bytes, high byte first, are compared with the CRC-16 (polynomial 0x1021, initial value 0, each byte processed most significant bit first) of that block's payload. A mismatch ends the transfer with result 1 and nothing more is fetched.
- R7: With crc_check low, the check bytes are fetched and ignored, and a wrong CRC still ends with result 0.
- R8: blk_count blocks are received in sequence, each with its own full token search budget, and a good run ends with result 0.
- R9: done is a one-cycle pulse. result is valid with it and stays unchanged until the next accepted start, and a start raised while busy is ignored.
- R10: At most one byte request is outstanding at a time; a new request follows only after spi_vld has returned the previous byte.
- R11: A start with blk_count of 0 raises done on the next cycle with result 0 and makes no byte request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a read phase (taken only when idle) |
| blk_count | input | CNT_W | Number of blocks to receive |
| blk_size | input | SZ_W | Payload bytes per block |
| tok_limit | input | LIM_W | Maximum bytes fetched per block while searching for 0xFE |
| crc_check | input | 1 | Enable comparison of the received CRC |
| spi_req | output | 1 | One-cycle request for the next byte from the SPI engine |
| spi_vld | input | 1 | Byte returned by the SPI engine is valid this cycle |
| spi_data | input | 8 | Byte returned by the SPI engine |
| out_valid | output | 1 | Payload byte available |
| out_ready | input | 1 | Consumer accepts the payload byte |
| out_data | output | 8 | Payload byte |
| busy | output | 1 | A read phase is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 none, 1 CRC mismatch, 2 token timeout |

## Verification
The embedded properties check on every cycle that the request line is quiet while a payload byte waits, that the payload byte holds under backpressure, and that only one request is outstanding. They also check that done lasts one cycle, that the result does not move while idle, and that a zero block count completes at once. Other behaviour can only be shown by the bench's scenarios against its reference card model: the exact count of bytes fetched when the token window runs out at its boundary, and the abort after a CRC mismatch in a middle block. The same holds for ignoring a bad CRC when checking is off and for the exact order of payload bytes across several blocks with random latency and random stalls.

// File: rtl/sdrd_pkg.sv
// Package: shared types, constants and the CRC step for the SD SPI block
// read receiver. Assumes bytes arrive most significant bit first on the wire.
package sdrd_pkg;

    localparam logic [7:0]  START_MARK = 8'hFE;
    localparam logic [15:0] CRC_POLY   = 16'h1021;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_CRC     = 2'd1,
        RES_TIMEOUT = 2'd2
    } rd_result_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TOK_REQ,
        S_TOK_WAIT,
        S_PAY_REQ,
        S_PAY_WAIT,
        S_PAY_OUT,
        S_CRC_REQ,
        S_CRC_WAIT
    } rd_state_e;

    // Advance a CRC-16 register by one byte, high bit of the byte first.
    function automatic logic [15:0] crc16_step(input logic [15:0] cur,
                                               input logic [7:0]  din);
        logic [15:0] c;
        logic        fb;
        c = cur;
        for (int b = 7; b >= 0; b--) begin
            fb = c[15] ^ din[b];
            c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return c;
    endfunction

endpackage

// File: rtl/sdrd_crc16.sv
// Module: running CRC-16 over the payload bytes of one block.
// Assumes clr and upd are never raised together; clr wins if they are.
module sdrd_crc16
    import sdrd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    // Accumulate the CRC, cleared at the start marker of each block.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc <= 16'h0000;
        end else if (upd) begin
            crc <= crc16_step(crc, din);
        end
    end

endmodule

// File: rtl/sdrd_outbuf.sv
// Module: one-entry holding register for the payload byte stream.
// Assumes load is only raised when the register is empty.
module sdrd_outbuf (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       taken
);

    assign taken = out_valid && out_ready;

    // Hold a byte until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= 8'h00;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (taken) begin
            out_valid <= 1'b0;
        end
    end

    // R5
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/sdrd_seq.sv
// Module: sequencer for the data phase. Searches for the start marker with a
// bounded budget, walks payload and check bytes, and reports the outcome.
// Assumes the SPI engine answers each request with exactly one spi_vld pulse.
module sdrd_seq
    import sdrd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SZ_W  = 12,
    parameter int LIM_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] blk_count,
    input  logic [SZ_W-1:0]  blk_size,
    input  logic [LIM_W-1:0] tok_limit,
    input  logic             crc_check,
    input  logic             spi_vld,
    input  logic [7:0]       spi_data,
    input  logic             taken,
    input  logic [15:0]      crc_val,
    output logic             spi_req,
    output logic             out_load,
    output logic             crc_clr,
    output logic             crc_upd,
    output logic             busy,
    output logic             done,
    output logic [1:0]       result
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [SZ_W-1:0]  SZ_ONE  = SZ_W'(1);
    localparam logic [LIM_W:0]   TRY_ONE = (LIM_W+1)'(1);

    rd_state_e        state;
    logic [CNT_W-1:0] blks_left;
    logic [SZ_W-1:0]  size_q;
    logic [LIM_W-1:0] limit_q;
    logic             chk_q;
    logic [LIM_W-1:0] tries;
    logic [SZ_W-1:0]  idx;
    logic             lo_phase;
    logic [7:0]       crc_hi_q;
    logic             done_q;
    rd_result_e       res_q;

    logic             is_mark;
    logic             budget_out;
    logic             crc_bad;

    // Decode of the byte being received and of the finish conditions.
    always_comb begin
        is_mark    = (spi_data == START_MARK);
        budget_out = (({1'b0, tries} + TRY_ONE) >= {1'b0, limit_q});
        crc_bad    = chk_q && (crc_val != {crc_hi_q, spi_data});
    end

    // Strobes to the byte engine, CRC and output register.
    always_comb begin
        spi_req  = (state == S_TOK_REQ) || (state == S_PAY_REQ) || (state == S_CRC_REQ);
        crc_clr  = (state == S_TOK_WAIT) && spi_vld && is_mark;
        crc_upd  = (state == S_PAY_WAIT) && spi_vld;
        out_load = (state == S_PAY_WAIT) && spi_vld;
        busy     = (state != S_IDLE);
        done     = done_q;
        result   = res_q;
    end

    // Main state machine of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            blks_left <= '0;
            size_q    <= '0;
            limit_q   <= '0;
            chk_q     <= 1'b0;
            tries     <= '0;
            idx       <= '0;
            lo_phase  <= 1'b0;
            crc_hi_q  <= 8'h00;
            done_q    <= 1'b0;
            res_q     <= RES_OK;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        res_q <= RES_OK;
                        if (blk_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            blks_left <= blk_count;
                            size_q    <= blk_size;
                            limit_q   <= tok_limit;
                            chk_q     <= crc_check;
                            tries     <= '0;
                            state     <= S_TOK_REQ;
                        end
                    end
                end
                S_TOK_REQ: state <= S_TOK_WAIT;
                S_TOK_WAIT: begin
                    if (spi_vld) begin
                        if (is_mark) begin
                            idx      <= '0;
                            lo_phase <= 1'b0;
                            state    <= (size_q == '0) ? S_CRC_REQ : S_PAY_REQ;
                        end else if (budget_out) begin
                            res_q  <= RES_TIMEOUT;
                            done_q <= 1'b1;
                            state  <= S_IDLE;
                        end else begin
                            tries <= tries + LIM_W'(1);
                            state <= S_TOK_REQ;
                        end
                    end
                end
                S_PAY_REQ: state <= S_PAY_WAIT;
                S_PAY_WAIT: begin
                    if (spi_vld) state <= S_PAY_OUT;
                end
                S_PAY_OUT: begin
                    if (taken) begin
                        if (idx == size_q - SZ_ONE) begin
                            lo_phase <= 1'b0;
                            state    <= S_CRC_REQ;
                        end else begin
                            idx   <= idx + SZ_ONE;
                            state <= S_PAY_REQ;
                        end
                    end
                end
                S_CRC_REQ: state <= S_CRC_WAIT;
                S_CRC_WAIT: begin
                    if (spi_vld) begin
                        if (!lo_phase) begin
                            crc_hi_q <= spi_data;
                            lo_phase <= 1'b1;
                            state    <= S_CRC_REQ;
                        end else if (crc_bad) begin
                            res_q  <= RES_CRC;
                            done_q <= 1'b1;
                            state  <= S_IDLE;
                        end else if (blks_left == CNT_ONE) begin
                            res_q  <= RES_OK;
                            done_q <= 1'b1;
                            state  <= S_IDLE;
                        end else begin
                            blks_left <= blks_left - CNT_ONE;
                            tries     <= '0;
                            state     <= S_TOK_REQ;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && blk_count == '0) |=> (done && result == 2'd0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));

    // R3
    try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && limit_q != '0) |-> (tries < limit_q));

endmodule

// File: rtl/sdrd_block_rx.sv
// Module: top of the SD SPI block read receiver. Joins the sequencer, the
// payload CRC and the output holding register.
// Assumes the SPI engine returns one byte per request after any latency.
module sdrd_block_rx #(
    parameter int CNT_W = 16,
    parameter int SZ_W  = 12,
    parameter int LIM_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] blk_count,
    input  logic [SZ_W-1:0]  blk_size,
    input  logic [LIM_W-1:0] tok_limit,
    input  logic             crc_check,
    output logic             spi_req,
    input  logic             spi_vld,
    input  logic [7:0]       spi_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             busy,
    output logic             done,
    output logic [1:0]       result
);

    logic        out_load;
    logic        taken;
    logic        crc_clr;
    logic        crc_upd;
    logic [15:0] crc_val;
    logic        pend_q;

    sdrd_seq #(.CNT_W(CNT_W), .SZ_W(SZ_W), .LIM_W(LIM_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .blk_count (blk_count),
        .blk_size  (blk_size),
        .tok_limit (tok_limit),
        .crc_check (crc_check),
        .spi_vld   (spi_vld),
        .spi_data  (spi_data),
        .taken     (taken),
        .crc_val   (crc_val),
        .spi_req   (spi_req),
        .out_load  (out_load),
        .crc_clr   (crc_clr),
        .crc_upd   (crc_upd),
        .busy      (busy),
        .done      (done),
        .result    (result)
    );

    sdrd_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .upd   (crc_upd),
        .din   (spi_data),
        .crc   (crc_val)
    );

    sdrd_outbuf u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (out_load),
        .load_data (spi_data),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .taken     (taken)
    );

    // Track a request that has not yet been answered by the SPI engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (spi_req) begin
            pend_q <= 1'b1;
        end else if (spi_vld) begin
            pend_q <= 1'b0;
        end
    end

    // R10
    single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |-> !pend_q);

    // R5
    no_req_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |-> !out_valid);

endmodule

// File: tb/sdrd_block_rx_bench.sv
module sdrd_block_rx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int SZ_W  = 12;
    localparam int LIM_W = 24;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] blk_count = '0;
    logic [SZ_W-1:0]  blk_size = '0;
    logic [LIM_W-1:0] tok_limit = '0;
    logic             crc_check = 1'b0;
    logic             spi_req;
    logic             spi_vld = 1'b0;
    logic [7:0]       spi_data = 8'h00;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [7:0]       out_data;
    logic             busy;
    logic             done;
    logic [1:0]       result;

    sdrd_block_rx #(.CNT_W(CNT_W), .SZ_W(SZ_W), .LIM_W(LIM_W)) u_sdrd_block_rx (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count),
        .blk_size(blk_size), .tok_limit(tok_limit), .crc_check(crc_check),
        .spi_req(spi_req), .spi_vld(spi_vld), .spi_data(spi_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .busy(busy), .done(done), .result(result)
    );

    // Reference state
    logic [7:0] card_q[$];
    logic [7:0] exp_q[$];
    int total = 0, bad = 0, cycles = 0;
    int exp_reqs = 0, req_seen = 0, exp_err = 0, lim_eff = 1;
    int out_cnt = 0, exp_out = 0, done_cnt = 0, last_res = 0;
    bit cur_chk = 0, aborted = 0, rdy_rand = 0;
    bit pend = 0, prev_stall = 0;
    int lat_cnt = 0;
    logic [7:0] prev_data = 8'h00;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [7:0] p[$]);
        int c = 0;
        foreach (p[i]) begin
            for (int b = 7; b >= 0; b--) begin
                int top = ((c >> 15) & 1) ^ ((p[i] >> b) & 1);
                c = (c << 1) & 16'hFFFF;
                if (top != 0) c = c ^ 16'h1021;
            end
        end
        return c[15:0];
    endfunction

    // Card model, consumer and per-clock comparison with the reference.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(0, "watchdog", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (rst_n) begin
            if (spi_vld) spi_vld = 1'b0;
            if (pend) begin
                if (lat_cnt <= 1) begin
                    spi_vld  = 1'b1;
                    spi_data = (card_q.size() > 0) ? card_q.pop_front() : 8'hFF;
                    pend     = 0;
                end else lat_cnt--;
            end
            if (spi_req) begin
                // R10: no second request before the first is answered
                if (pend || spi_vld) check(0, "R10", 1, 0);
                // R5: no request while a payload byte waits
                if (out_valid) check(0, "R5", 1, 0);
                pend = 1; lat_cnt = 1 + $urandom % 3; req_seen++;
            end
            // R5: data held under stall
            if (prev_stall) begin
                total++;
                if (!(out_valid && out_data == prev_data)) begin
                    bad++;
                    $display("FAIL R5 actual=%0h expected=%0h", out_data, prev_data);
                end
            end
            out_ready = rdy_rand ? ($urandom % 2 == 1) : 1'b1;
            if (out_valid && out_ready) begin
                out_cnt++;
                if (exp_q.size() == 0) check(0, "R4", out_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, "R4", out_data, e);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (done) begin
                last_res = result;
                done_cnt++;
            end
        end
    end

    task automatic prep(input int limit, input bit chk, input bit rr);
        card_q.delete(); exp_q.delete();
        exp_reqs = 0; req_seen = 0; exp_err = 0; aborted = 0;
        out_cnt = 0; exp_out = 0;
        lim_eff = (limit == 0) ? 1 : limit;
        cur_chk = chk; rdy_rand = rr;
    endtask

    task automatic add_block(input int gap, input int size, input bit corrupt, input int seed);
        logic [7:0] pay[$];
        logic [15:0] c;
        if (aborted) return;
        for (int i = 0; i < gap; i++) card_q.push_back(8'hFF);
        if (gap >= lim_eff) begin
            exp_reqs += lim_eff; exp_err = 2; aborted = 1;
            return;
        end
        card_q.push_back(8'hFE);
        for (int i = 0; i < size; i++) begin
            logic [7:0] v;
            v = 8'((seed * 53 + i * 29 + 7) & 255);
            pay.push_back(v); card_q.push_back(v); exp_q.push_back(v);
        end
        exp_out += size;
        c = ref_crc(pay);
        if (corrupt) c = c ^ 16'h0001;
        card_q.push_back(c[15:8]); card_q.push_back(c[7:0]);
        exp_reqs += gap + 1 + size + 2;
        if (corrupt && cur_chk) begin exp_err = 1; aborted = 1; end
    endtask

    task automatic go(input int cnt, input int size, input int limit, input bit chk,
                      input bit poke, input string req);
        int d0;
        int w;
        d0 = done_cnt;
        @(negedge clk);
        blk_count = CNT_W'(cnt); blk_size = SZ_W'(size);
        tok_limit = LIM_W'(limit); crc_check = chk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (done_cnt == d0) begin
            @(negedge clk);
            w++;
            if (poke && w == 10) begin
                check(busy == 1'b1, "R9", busy, 1);
                start = 1'b1; blk_count = '0;
                @(negedge clk);
                start = 1'b0; blk_count = CNT_W'(cnt);
            end
        end
        check(last_res == exp_err, req, last_res, exp_err);
        repeat (8) @(negedge clk);
        check(req_seen == exp_reqs, req, req_seen, exp_reqs);
        // R2: only payload bytes were delivered
        check(out_cnt == exp_out, "R2", out_cnt, exp_out);
        // R9: result held after completion
        check(result == 2'(exp_err), "R9", result, exp_err);
        check(done == 1'b0, "R9", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(spi_req == 1'b0 && out_valid == 1'b0, "R1", {spi_req, out_valid}, 0);
        check(done == 1'b0 && busy == 1'b0 && result == 2'd0, "R1", {done, busy, result}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(spi_req == 1'b0 && busy == 1'b0, "R1", {spi_req, busy}, 0);

        // R4 R6: single good block, CRC checked
        prep(20, 1, 0);
        add_block(3, 16, 0, 1);
        go(1, 16, 20, 1, 0, "R6");

        // R8: three blocks, varied gaps, random stalls
        prep(20, 1, 1);
        add_block(0, 8, 0, 2); add_block(5, 8, 0, 3); add_block(2, 8, 0, 4);
        go(3, 8, 20, 1, 0, "R8");

        // R6: bad CRC in middle block aborts
        prep(20, 1, 1);
        add_block(1, 6, 0, 5); add_block(2, 6, 1, 6); add_block(1, 6, 0, 7);
        go(3, 6, 20, 1, 0, "R6");

        // R7: bad CRC ignored when checking is off
        prep(20, 0, 0);
        add_block(1, 6, 0, 8); add_block(2, 6, 1, 9); add_block(1, 6, 0, 10);
        go(3, 6, 20, 0, 0, "R7");

        // R3: gap one short of the limit passes, gap equal to the limit times out
        prep(6, 1, 0);
        add_block(5, 4, 0, 11); add_block(6, 4, 0, 12);
        go(2, 4, 6, 1, 0, "R3");

        // R3: a limit of 0 acts as 1
        prep(0, 1, 0);
        add_block(1, 4, 0, 13);
        go(1, 4, 0, 1, 0, "R3");

        // R11: zero block count
        prep(20, 1, 0);
        go(0, 4, 20, 1, 0, "R11");

        // R9: start while busy ignored, 16-byte register read
        prep(20, 1, 1);
        add_block(2, 16, 0, 14);
        go(1, 16, 20, 1, 1, "R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule